// File: doc/BRIEF.md
# Size-Class Slab Free Pool

This block hands out and takes back fixed-size memory slabs. Slabs come in five power-of-two classes from 32 to 512 bytes. An allocate request carries a byte size. The block rounds it up to the smallest class that holds it and answers one cycle later with a slab address taken from that class. A free request returns an address to the class the caller names.

Each class keeps its own on-chip last-in-first-out stack of free addresses. This stack is a cache of a larger host-side pool, and the two are synchronised in batches only.

A host-facing state machine keeps each stack inside its band:
- When a stack runs low, the machine asks the host for a batch of addresses, and the host then streams them in.
- When a stack grows too full, the machine streams a batch back to the host.
- After every few returned batches it raises a lazy merge request. The host then folds small free slabs into larger ones with its own global allocation bitmap, at its own pace.

The host-side merge and the transport are outside this block.

The state machine has three states:
- `ST_IDLE` scans the stacks. It moves to `ST_SPILL` when a stack is over its high mark (spill has precedence). Otherwise it moves to `ST_REQ` when a stack is under its low mark and has no refill outstanding. The lowest class index wins in both cases.
- `ST_REQ` presents a refill request and returns to `ST_IDLE` when the host accepts it.
- `ST_SPILL` pops one entry per accepted beat and returns to `ST_IDLE` after the last beat of the batch.

Top module: `slab_free_pool`

## Requirements
- R1: An accepted allocate of size S (S ≤ 512) answers with `resp_class` = the smallest k in 0..4 with S ≤ 32·2^k. Class code k means 32·2^k bytes, and a size of 0 maps to class 0.
- R2: An allocate with size above 512 is accepted without stalling. It answers with `resp_err`=1, `resp_addr`=0 and `resp_class`=0, and it leaves every stack untouched.
- R3: The response appears on the cycle after the accepting edge. Its address is the entry most recently pushed into that class, whether by free or by fill (LIFO order).
- R4: A free and an allocate presented in the same cycle are served free-first. While `free_valid` is high, `alloc_ready` is low.
- R5: A class holding fewer than 8 entries with no refill outstanding raises `refill_req_valid` with `refill_req_class`. The request is held stable until `refill_req_ready`, and the lowest class index goes first. The class stays outstanding until a fill beat for it carries `fill_last`.
- R6: Each accepted fill beat pushes `fill_addr` onto class `fill_class`. `fill_ready` is low while a spill is in progress or that class holds 64 entries. A fill beat has priority over free and allocate.
- R7: An allocate for a class whose stack is empty holds `alloc_ready` low and produces no response. It completes only after entries reach that class.
- R8: A class holding more than 56 entries is spilled before any refill request is made. The spill streams exactly 32 entries from the top of its stack, each with `spill_valid` and `spill_class`. Fill, free and allocate are held off meanwhile.
- R9: When every 2nd spill batch completes, `merge_req` rises. It stays high until a cycle with `merge_ack`.
- R10: While reset is active, all stacks are empty and no request, response or spill is valid. The first refill request after reset names class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate request present |
| alloc_ready | output | 1 | Allocate request accepted this cycle |
| alloc_size | input | 16 | Requested size in bytes |
| free_valid | input | 1 | Free request present |
| free_ready | output | 1 | Free request accepted this cycle |
| free_addr | input | 32 | Address being returned |
| free_class | input | 3 | Class code of the returned slab |
| resp_valid | output | 1 | Allocate response valid |
| resp_addr | output | 32 | Allocated slab address |
| resp_class | output | 3 | Class code of the allocated slab |
| resp_err | output | 1 | Size above the largest class |
| refill_req_valid | output | 1 | Batch refill wanted |
| refill_req_ready | input | 1 | Host accepts the refill request |
| refill_req_class | output | 3 | Class to refill |
| fill_valid | input | 1 | Host delivers one free address |
| fill_ready | output | 1 | Fill beat accepted |
| fill_addr | input | 32 | Delivered address |
| fill_class | input | 3 | Class of the delivered address |
| fill_last | input | 1 | Final beat of a refill batch |
| spill_valid | output | 1 | Spill beat present |
| spill_ready | input | 1 | Host takes the spill beat |
| spill_addr | output | 32 | Returned address |
| spill_class | output | 3 | Class of the returned address |
| merge_req | output | 1 | Lazy merge wanted |
| merge_ack | input | 1 | Host takes the merge request |

## Verification
Stack damage appears at the ports on the very next allocate of the affected class.
- A lost push or a corrupted pointer gives a response address that differs from the LIFO order the bench keeps.
- A miscounted depth changes the cycle in which a refill or spill request appears, or the number of spill beats.

The bench compares every response, spill beat and request class against its own model. Most faults are therefore caught on the first transaction after the fault, or within one spill batch.

// File: rtl/slab_pool_pkg.sv
package slab_pool_pkg;
    localparam int unsigned SP_CLASSES     = 5;
    localparam int unsigned SP_MIN_SHIFT   = 5;
    localparam int unsigned SP_DEPTH       = 64;
    localparam int unsigned SP_LOW         = 8;
    localparam int unsigned SP_HIGH        = 56;
    localparam int unsigned SP_BATCH       = 32;
    localparam int unsigned SP_MERGE_EVERY = 2;
    localparam int unsigned SP_ADDR_W      = 32;
    localparam int unsigned SP_SIZE_W      = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_SPILL = 2'd2
    } host_state_e;
endpackage

// File: rtl/slab_size_map.sv
module slab_size_map #(
    parameter int unsigned CLASSES   = 5,
    parameter int unsigned MIN_SHIFT = 5,
    parameter int unsigned SIZE_W    = 16,
    parameter int unsigned CLS_W     = 3
) (
    input  logic [SIZE_W-1:0] size,
    output logic [CLS_W-1:0]  cls,
    output logic              too_big
);
    localparam logic [31:0] MAX_BYTES = 32'd1 << (MIN_SHIFT + CLASSES - 1);

    logic [31:0] size_ext;
    assign size_ext = 32'(size);

    // Scan from the largest class down so the smallest fitting class is kept (R1).
    always_comb begin
        cls     = '0;
        too_big = (size_ext > MAX_BYTES);
        for (int k = int'(CLASSES) - 1; k >= 0; k--) begin
            if (size_ext <= (32'd1 << (MIN_SHIFT + k))) begin
                cls = CLS_W'(k);
            end
        end
    end
endmodule

// File: rtl/slab_class_stack.sv
module slab_class_stack #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          pop,
    input  logic [ADDR_W-1:0]             din,
    output logic [ADDR_W-1:0]             top,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    assign wr_ptr = PTR_W'(count);
    assign rd_ptr = PTR_W'(count - CNT_W'(1));
    assign top    = (count == '0) ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (push) begin
            count <= count + CNT_W'(1);
        end else if (pop) begin
            count <= count - CNT_W'(1);
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
    assert_push_pop_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/slab_host_fsm.sv
module slab_host_fsm
    import slab_pool_pkg::*;
#(
    parameter int unsigned CLASSES     = 5,
    parameter int unsigned CNT_W       = 7,
    parameter int unsigned CLS_W       = 3,
    parameter int unsigned LOW         = 8,
    parameter int unsigned HIGH        = 56,
    parameter int unsigned BATCH       = 32,
    parameter int unsigned MERGE_EVERY = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [CLASSES-1:0][CNT_W-1:0]   counts,
    input  logic                            refill_req_ready,
    input  logic                            fill_done,
    input  logic [CLS_W-1:0]                fill_cls,
    input  logic                            spill_beat,
    input  logic                            merge_ack,
    output logic                            refill_req_valid,
    output logic [CLS_W-1:0]                refill_req_class,
    output logic                            spill_active,
    output logic [CLS_W-1:0]                spill_cls,
    output logic                            merge_req
);
    localparam int unsigned BEAT_W = $clog2(BATCH);
    localparam int unsigned MCNT_W = $clog2(MERGE_EVERY + 1);

    host_state_e         state, nxt;
    logic [CLS_W-1:0]    cur_cls;
    logic [BEAT_W-1:0]   beat;
    logic [CLASSES-1:0]  pending;
    logic [MCNT_W-1:0]   spill_tally;
    logic                over_any, need_any, last_beat;
    logic [CLS_W-1:0]    over_cls, need_cls;

    // Lowest class index wins for both spill and refill selection.
    always_comb begin
        over_any = 1'b0;
        need_any = 1'b0;
        over_cls = '0;
        need_cls = '0;
        for (int k = int'(CLASSES) - 1; k >= 0; k--) begin
            if (counts[k] > CNT_W'(HIGH)) begin
                over_any = 1'b1;
                over_cls = CLS_W'(k);
            end
            if ((counts[k] < CNT_W'(LOW)) && !pending[k]) begin
                need_any = 1'b1;
                need_cls = CLS_W'(k);
            end
        end
    end

    assign last_beat = (state == ST_SPILL) && spill_beat && (beat == BEAT_W'(BATCH - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (over_any) nxt = ST_SPILL;
                      else if (need_any) nxt = ST_REQ;
            ST_REQ:   if (refill_req_ready) nxt = ST_IDLE;
            ST_SPILL: if (last_beat) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cls <= '0;
            beat    <= '0;
        end else begin
            if (state == ST_IDLE) begin
                cur_cls <= over_any ? over_cls : need_cls;
                beat    <= '0;
            end else if ((state == ST_SPILL) && spill_beat) begin
                beat <= beat + BEAT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else begin
            if (fill_done) pending[fill_cls] <= 1'b0;
            if ((state == ST_REQ) && refill_req_ready) pending[cur_cls] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spill_tally <= '0;
            merge_req   <= 1'b0;
        end else begin
            if (merge_req && merge_ack) merge_req <= 1'b0;
            if (last_beat) begin
                if (spill_tally == MCNT_W'(MERGE_EVERY - 1)) begin
                    spill_tally <= '0;
                    merge_req   <= 1'b1;
                end else begin
                    spill_tally <= spill_tally + MCNT_W'(1);
                end
            end
        end
    end

    always_comb begin
        refill_req_valid = (state == ST_REQ);
        refill_req_class = cur_cls;
        spill_active     = (state == ST_SPILL);
        spill_cls        = cur_cls;
    end

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req_valid && !refill_req_ready) |=> (refill_req_valid && $stable(refill_req_class)));
    assert_req_fresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refill_req_valid) |-> !pending[refill_req_class]);
    assert_spill_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spill_active |-> (counts[spill_cls] != '0));
    assert_merge_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_req && !merge_ack) |=> merge_req);
endmodule

// File: rtl/slab_free_pool.sv
module slab_free_pool
    import slab_pool_pkg::*;
#(
    parameter int unsigned CLASSES     = SP_CLASSES,
    parameter int unsigned MIN_SHIFT   = SP_MIN_SHIFT,
    parameter int unsigned DEPTH       = SP_DEPTH,
    parameter int unsigned LOW         = SP_LOW,
    parameter int unsigned HIGH        = SP_HIGH,
    parameter int unsigned BATCH       = SP_BATCH,
    parameter int unsigned MERGE_EVERY = SP_MERGE_EVERY,
    parameter int unsigned ADDR_W      = SP_ADDR_W,
    parameter int unsigned SIZE_W      = SP_SIZE_W,
    localparam int unsigned CLS_W      = $clog2(CLASSES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic [SIZE_W-1:0] alloc_size,
    input  logic              free_valid,
    output logic              free_ready,
    input  logic [ADDR_W-1:0] free_addr,
    input  logic [CLS_W-1:0]  free_class,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_addr,
    output logic [CLS_W-1:0]  resp_class,
    output logic              resp_err,
    output logic              refill_req_valid,
    input  logic              refill_req_ready,
    output logic [CLS_W-1:0]  refill_req_class,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [CLS_W-1:0]  fill_class,
    input  logic              fill_last,
    output logic              spill_valid,
    input  logic              spill_ready,
    output logic [ADDR_W-1:0] spill_addr,
    output logic [CLS_W-1:0]  spill_class,
    output logic              merge_req,
    input  logic              merge_ack
);
    localparam int unsigned CNT_W     = $clog2(DEPTH + 1);
    localparam logic [31:0] MAX_BYTES = 32'd1 << (MIN_SHIFT + CLASSES - 1);

    logic [CLASSES-1:0][CNT_W-1:0]  counts;
    logic [CLASSES-1:0][ADDR_W-1:0] tops;
    logic [CLASSES-1:0]             push_c, pop_c;
    logic [ADDR_W-1:0]              push_data;
    logic [CLS_W-1:0]               a_cls, spill_cls, fill_idx, free_idx;
    logic                           a_big, spill_active;
    logic                           fill_ok, free_ok;
    logic                           fill_push, free_push, alloc_take, alloc_pop, spill_pop;

    slab_size_map #(
        .CLASSES(CLASSES), .MIN_SHIFT(MIN_SHIFT), .SIZE_W(SIZE_W), .CLS_W(CLS_W)
    ) u_map (
        .size(alloc_size), .cls(a_cls), .too_big(a_big)
    );

    slab_host_fsm #(
        .CLASSES(CLASSES), .CNT_W(CNT_W), .CLS_W(CLS_W), .LOW(LOW),
        .HIGH(HIGH), .BATCH(BATCH), .MERGE_EVERY(MERGE_EVERY)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .counts(counts),
        .refill_req_ready(refill_req_ready),
        .fill_done(fill_push && fill_last), .fill_cls(fill_idx),
        .spill_beat(spill_pop), .merge_ack(merge_ack),
        .refill_req_valid(refill_req_valid), .refill_req_class(refill_req_class),
        .spill_active(spill_active), .spill_cls(spill_cls), .merge_req(merge_req)
    );

    // One pool operation per cycle: spill, then fill, then free, then allocate.
    always_comb begin
        fill_ok     = (32'(fill_class) < CLASSES);
        free_ok     = (32'(free_class) < CLASSES);
        fill_idx    = fill_ok ? fill_class : '0;
        free_idx    = free_ok ? free_class : '0;
        spill_valid = spill_active;
        spill_class = spill_cls;
        spill_addr  = tops[spill_cls];
        spill_pop   = spill_active && spill_ready;
        fill_ready  = !spill_active && fill_ok && (counts[fill_idx] != CNT_W'(DEPTH));
        free_ready  = !spill_active && !fill_valid && free_ok
                      && (counts[free_idx] != CNT_W'(DEPTH));
        alloc_ready = !spill_active && !fill_valid && !free_valid
                      && (a_big || (counts[a_cls] != '0));
        fill_push   = fill_valid && fill_ready;
        free_push   = free_valid && free_ready;
        alloc_take  = alloc_valid && alloc_ready;
        alloc_pop   = alloc_take && !a_big;
        push_data   = fill_push ? fill_addr : free_addr;
    end

    for (genvar c = 0; c < int'(CLASSES); c++) begin : g_class
        assign push_c[c] = (fill_push && (fill_idx == CLS_W'(c)))
                        || (free_push && (free_idx == CLS_W'(c)));
        assign pop_c[c]  = (spill_pop && (spill_cls == CLS_W'(c)))
                        || (alloc_pop && (a_cls == CLS_W'(c)));

        slab_class_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_stack (
            .clk(clk), .rst_n(rst_n), .push(push_c[c]), .pop(pop_c[c]),
            .din(push_data), .top(tops[c]), .count(counts[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_addr  <= '0;
            resp_class <= '0;
            resp_err   <= 1'b0;
        end else begin
            resp_valid <= alloc_take;
            if (alloc_take) begin
                resp_err   <= a_big;
                resp_class <= a_big ? '0 : a_cls;
                resp_addr  <= a_big ? '0 : tops[a_cls];
            end
        end
    end

    assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({spill_pop, fill_push, free_push, alloc_take}) <= 1);
    assert_size_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> (32'($past(alloc_size)) > MAX_BYTES));
    assert_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_err) |-> $past(counts[a_cls] != '0));
    assert_quiet_spill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spill_active |=> !resp_valid);
endmodule

// File: tb/sim_slab_free_pool.sv
`timescale 1ns/1ps
module sim_slab_free_pool;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0, free_valid = 1'b0, fill_valid = 1'b0, fill_last = 1'b0;
    logic        refill_req_ready = 1'b0, spill_ready = 1'b0, merge_ack = 1'b0;
    logic [15:0] alloc_size = '0;
    logic [31:0] free_addr = '0, fill_addr = '0;
    logic [2:0]  free_class = '0, fill_class = '0;
    logic        alloc_ready, free_ready, resp_valid, resp_err, refill_req_valid;
    logic        fill_ready, spill_valid, merge_req;
    logic [31:0] resp_addr, spill_addr;
    logic [2:0]  resp_class, refill_req_class, spill_class;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mdl [5][64];
    int mcnt [5];
    int serial = 0;

    always #2.5 clk = ~clk;

    slab_free_pool u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_size(alloc_size),
        .free_valid(free_valid), .free_ready(free_ready), .free_addr(free_addr),
        .free_class(free_class),
        .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_class(resp_class),
        .resp_err(resp_err),
        .refill_req_valid(refill_req_valid), .refill_req_ready(refill_req_ready),
        .refill_req_class(refill_req_class),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
        .fill_class(fill_class), .fill_last(fill_last),
        .spill_valid(spill_valid), .spill_ready(spill_ready), .spill_addr(spill_addr),
        .spill_class(spill_class), .merge_req(merge_req), .merge_ack(merge_ack)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_class(input int size);
        for (int k = 0; k < 5; k++) if (size <= (32 << k)) return k;
        return 0;
    endfunction

    task automatic do_alloc(input int size);
        int c;
        logic [31:0] ea;
        c = exp_class(size);
        @(negedge clk);
        alloc_valid = 1'b1;
        alloc_size  = 16'(size);
        #1;
        while (!alloc_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1 alloc_valid = 1'b0;
        @(negedge clk);
        check("R3 resp_valid", longint'(resp_valid), 1);
        if (size > 512) begin
            check("R2 err", longint'(resp_err), 1);
            check("R2 addr", longint'(resp_addr), 0);
            check("R2 class", longint'(resp_class), 0);
        end else begin
            ea = mdl[c][mcnt[c]-1];
            mcnt[c]--;
            check("R1 class", longint'(resp_class), c);
            check("R2 no err", longint'(resp_err), 0);
            check("R3 addr", longint'(resp_addr), longint'(ea));
        end
    endtask

    task automatic do_free(input logic [31:0] a, input int c);
        @(negedge clk);
        free_valid = 1'b1;
        free_addr  = a;
        free_class = 3'(c);
        #1;
        while (!free_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1 free_valid = 1'b0;
        mdl[c][mcnt[c]] = a;
        mcnt[c]++;
    endtask

    task automatic host_refill(input int c);
        @(negedge clk); #1;
        while (!refill_req_valid) begin @(negedge clk); #1; end
        check("R5 refill class", longint'(refill_req_class), c);
        refill_req_ready = 1'b1;
        @(posedge clk);
        #1 refill_req_ready = 1'b0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            fill_valid = 1'b1;
            fill_class = 3'(c);
            fill_addr  = 32'h1000_0000 + 32'(c) * 32'h0100_0000 + 32'(serial) * (32'd32 << c);
            fill_last  = (i == 31);
            #1;
            while (!fill_ready) begin @(negedge clk); #1; end
            @(posedge clk);
            mdl[c][mcnt[c]] = fill_addr;
            mcnt[c]++;
            serial++;
        end
        #1 fill_valid = 1'b0;
        fill_last = 1'b0;
    endtask

    task automatic take_spill(input int c);
        @(negedge clk); #1;
        while (!spill_valid) begin @(negedge clk); #1; end
        check("R8 fill held off", longint'(fill_ready), 0);
        check("R8 free held off", longint'(free_ready), 0);
        spill_ready = 1'b1;
        for (int i = 0; i < 32; i++) begin
            check("R8 spill valid", longint'(spill_valid), 1);
            check("R8 spill class", longint'(spill_class), c);
            check("R8 spill addr", longint'(spill_addr), longint'(mdl[c][mcnt[c]-1]));
            @(posedge clk);
            mcnt[c]--;
            @(negedge clk); #1;
        end
        spill_ready = 1'b0;
        check("R8 exactly 32 beats", longint'(spill_valid), 0);
    endtask

    task automatic fill_to_spill(input int c);
        int n;
        n = 57 - mcnt[c];
        for (int i = 0; i < n; i++) do_free(32'hF000_0000 + 32'(c << 12) + 32'(i << 5), c);
        take_spill(c);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 5; k++) mcnt[k] = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        alloc_valid = 1'b1; alloc_size = 16'd32; #1;
        check("R10 no refill in reset", longint'(refill_req_valid), 0);
        check("R10 no spill in reset", longint'(spill_valid), 0);
        check("R10 no resp in reset", longint'(resp_valid), 0);
        check("R10 no merge in reset", longint'(merge_req), 0);
        check("R10 empty pool stalls", longint'(alloc_ready), 0);
        alloc_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R10/R5/R6: initial refills in class order
        for (int k = 0; k < 5; k++) host_refill(k);

        // R1/R2/R3: size sweep over the class boundaries
        begin
            int sizes [19] = '{0, 1, 31, 32, 33, 63, 64, 65, 127, 128, 129,
                               255, 256, 257, 511, 512, 513, 1000, 65535};
            foreach (sizes[i]) do_alloc(sizes[i]);
        end

        // R4: free-first when both arrive together
        @(negedge clk);
        free_valid = 1'b1; free_addr = 32'hABCD_0040; free_class = 3'd2;
        alloc_valid = 1'b1; alloc_size = 16'd100;
        #1;
        check("R4 alloc held by free", longint'(alloc_ready), 0);
        check("R4 free accepted", longint'(free_ready), 1);
        @(posedge clk);
        #1 free_valid = 1'b0;
        mdl[2][mcnt[2]] = 32'hABCD_0040; mcnt[2]++;
        do_alloc(100);

        // R8/R9: two spills, merge after the second
        fill_to_spill(0);
        check("R9 no merge after one spill", longint'(merge_req), 0);
        fill_to_spill(1);
        check("R9 merge after two spills", longint'(merge_req), 1);
        repeat (3) @(negedge clk);
        check("R9 merge held", longint'(merge_req), 1);
        merge_ack = 1'b1;
        @(posedge clk);
        #1 merge_ack = 1'b0;
        @(negedge clk);
        check("R9 merge cleared by ack", longint'(merge_req), 0);

        // R7: drain class 4 and stall on empty
        while (mcnt[4] > 0) do_alloc(512);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_size = 16'd300;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check("R7 stall ready low", longint'(alloc_ready), 0);
            check("R7 no response", longint'(resp_valid), 0);
        end
        check("R5 refill pending for class 4", longint'(refill_req_valid), 1);
        check("R5 refill class 4", longint'(refill_req_class), 4);
        alloc_valid = 1'b0;
        host_refill(4);
        do_alloc(300);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule